// File: doc/BRIEF.md
# Battery Charge-Path Protection Sequencer

This block decides when the charge switch of a two-cell battery pack may stay on. It takes comparator results that are already digital: a per-cell over-voltage flag, a per-cell "back below release level" flag, a flag that the negative terminal sits above the over-current level (a load is attached), and a flag that the charger voltage is too high. It also takes the enable state of the companion discharge-path block and a test-mode pin. Every condition must hold without a break for a counted number of ticks of a fixed-rate timebase before the output changes.

The block drives one level output, the charge enable, and one select line back to the analog side. The select line asks the release comparators to use their small-hysteresis threshold while the pack is over-charged and a load is attached. A separate input forces the charge enable high so that cells at zero volts can still be charged. All ports are plain levels sampled on the clock; there is no data stream and so no valid/ready handshake.

Top module: `chg_guard`

## Requirements
- R1: Over-charge trips when either bit of `oc_cell` stays high for OC_DET_TICKS consecutive clocks with `tick` high. `chg_en` goes low after the clock edge that counts the last tick.
- R2: From the over-charged state, `chg_en` returns high after both bits of `below_rel` stay high for OC_REL_TICKS consecutive ticks.
- R3: `hyst_cancel` is high exactly while over-charge is latched and `load_present` is high.
- R4: If a detect or release condition drops for a single clock, its count restarts from zero.
- R5: With `dsg_en` high, `hv_charger` held for XC_DET_TICKS ticks drives `chg_en` low. If `hv_charger` clears before then, the count is abandoned.
- R6: A latched excessive-charger state releases after `hv_charger` stays low for XC_REL_TICKS ticks.
- R7: While `dsg_en` is low, the excessive-charger count does not advance. It starts from zero once `dsg_en` is high.
- R8: When over-charge releases while `hv_charger` and `dsg_en` are both high, the excessive-charger state latches on that same edge, so `chg_en` stays low without a gap.
- R9: With `test_mode` high, each count becomes its nominal value divided by TEST_DIV, with a minimum of 1.
- R10: `zero_cell_chg` high forces `chg_en` high at once, in the same cycle and with no delay.
- R11: After reset, `chg_en` is high, `hyst_cancel` is low and all counts are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Timebase strobe; counts advance only on clocks where it is high |
| test_mode | input | 1 | Selects the shortened counts |
| oc_cell | input | 2 | Per-cell at-or-above over-charge threshold |
| below_rel | input | 2 | Per-cell at-or-below release threshold |
| load_present | input | 1 | Negative terminal above the over-current level |
| hv_charger | input | 1 | Charger voltage too high |
| dsg_en | input | 1 | Discharge switch enable from the companion block |
| zero_cell_chg | input | 1 | Zero-volt cell charge condition; forces charge enable |
| chg_en | output | 1 | Charge switch enable |
| hyst_cancel | output | 1 | Small-hysteresis select for the release comparators |

## Verification
A detect or release result is due on the N-th rising edge after its condition is applied, where N is the active count for that timer. `tick` is held high throughout, so N equals the tick count. The bench drives inputs on falling edges. It samples one falling edge before the due edge to confirm that nothing has changed yet, and then samples again just after the due edge. `hyst_cancel` and the forced enable are combinational from state and inputs, so they are checked one time unit after the input changes.

// File: rtl/chg_guard_pkg.sv
package chg_guard_pkg;
  function automatic int scaled_count(input int nominal, input int div);
    int q;
    q = nominal / div;
    return (q < 1) ? 1 : q;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NUM_TIMERS = 4;
  localparam int T_OC_DET = 0;
  localparam int T_OC_REL = 1;
  localparam int T_XC_DET = 2;
  localparam int T_XC_REL = 3;
endpackage

// File: rtl/chg_qual_timer.sv
module chg_qual_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cond,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = cond && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!cond || done)  cnt <= '0;
    else if (tick)           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/chg_guard.sv
module chg_guard
  import chg_guard_pkg::*;
#(
  parameter int OC_DET_TICKS = 2000,
  parameter int OC_REL_TICKS = 80,
  parameter int XC_DET_TICKS = 3,
  parameter int XC_REL_TICKS = 3,
  parameter int TEST_DIV     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       test_mode,
  input  logic [1:0] oc_cell,
  input  logic [1:0] below_rel,
  input  logic       load_present,
  input  logic       hv_charger,
  input  logic       dsg_en,
  input  logic       zero_cell_chg,
  output logic       chg_en,
  output logic       hyst_cancel
);
  localparam int MAXT = max2(max2(OC_DET_TICKS, OC_REL_TICKS),
                             max2(XC_DET_TICKS, XC_REL_TICKS));
  localparam int CW = $clog2(MAXT + 1);

  localparam logic [CW-1:0] NOM_OC_DET = CW'(OC_DET_TICKS);
  localparam logic [CW-1:0] NOM_OC_REL = CW'(OC_REL_TICKS);
  localparam logic [CW-1:0] NOM_XC_DET = CW'(XC_DET_TICKS);
  localparam logic [CW-1:0] NOM_XC_REL = CW'(XC_REL_TICKS);
  localparam logic [CW-1:0] TST_OC_DET = CW'(scaled_count(OC_DET_TICKS, TEST_DIV));
  localparam logic [CW-1:0] TST_OC_REL = CW'(scaled_count(OC_REL_TICKS, TEST_DIV));
  localparam logic [CW-1:0] TST_XC_DET = CW'(scaled_count(XC_DET_TICKS, TEST_DIV));
  localparam logic [CW-1:0] TST_XC_REL = CW'(scaled_count(XC_REL_TICKS, TEST_DIV));

  logic oc_lat, xc_lat;
  logic [NUM_TIMERS-1:0] t_cond, t_done;
  logic [CW-1:0] t_limit [NUM_TIMERS];

  // Conditions per timer; a timer only runs in the state where it applies.
  always_comb begin
    t_cond[T_OC_DET] = !oc_lat && (|oc_cell);
    t_cond[T_OC_REL] =  oc_lat && (&below_rel);
    t_cond[T_XC_DET] = !oc_lat && !xc_lat && hv_charger && dsg_en;
    t_cond[T_XC_REL] =  xc_lat && !hv_charger;
    t_limit[T_OC_DET] = test_mode ? TST_OC_DET : NOM_OC_DET;
    t_limit[T_OC_REL] = test_mode ? TST_OC_REL : NOM_OC_REL;
    t_limit[T_XC_DET] = test_mode ? TST_XC_DET : NOM_XC_DET;
    t_limit[T_XC_REL] = test_mode ? TST_XC_REL : NOM_XC_REL;
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    chg_qual_timer #(.CW(CW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .cond  (t_cond[i]),
      .limit (t_limit[i]),
      .done  (t_done[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                oc_lat <= 1'b0;
    else if (t_done[T_OC_DET]) oc_lat <= 1'b1;
    else if (t_done[T_OC_REL]) oc_lat <= 1'b0;
  end

  // Excessive-charger state; re-armed directly when over-charge releases.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      xc_lat <= 1'b0;
    else if (t_done[T_XC_DET] || (t_done[T_OC_REL] && hv_charger && dsg_en))
      xc_lat <= 1'b1;
    else if (t_done[T_XC_REL])
      xc_lat <= 1'b0;
  end

  assign chg_en      = zero_cell_chg || (!oc_lat && !xc_lat);
  assign hyst_cancel = oc_lat && load_present;
endmodule

// File: rtl/chg_guard_chk.sv
module chg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] oc_cell,
  input logic [1:0] below_rel,
  input logic       load_present,
  input logic       hv_charger,
  input logic       dsg_en,
  input logic       zero_cell_chg,
  input logic       chg_en,
  input logic       hyst_cancel,
  input logic       oc_lat,
  input logic       xc_lat
);
  p_oc_set_needs_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_lat) |-> $past(|oc_cell));

  p_oc_rel_needs_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_lat) |-> $past(&below_rel));

  p_hyst_needs_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hyst_cancel |-> (load_present && !chg_en) || zero_cell_chg || load_present);

  p_xc_rel_needs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xc_lat) |-> !$past(hv_charger));

  p_xc_set_needs_dsg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xc_lat) |-> $past(dsg_en) && $past(hv_charger));

  p_force_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cell_chg |-> chg_en);
endmodule

bind chg_guard chg_guard_chk u_chk (.*);

// File: tb/sim_chg_guard.sv
module sim_chg_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic test_mode = 1'b0;
  logic [1:0] oc_cell = 2'b00;
  logic [1:0] below_rel = 2'b00;
  logic load_present = 1'b0;
  logic hv_charger = 1'b0;
  logic dsg_en = 1'b1;
  logic zero_cell_chg = 1'b0;
  logic chg_en, hyst_cancel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_guard u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .test_mode(test_mode),
    .oc_cell(oc_cell), .below_rel(below_rel), .load_present(load_present),
    .hv_charger(hv_charger), .dsg_en(dsg_en), .zero_cell_chg(zero_cell_chg),
    .chg_en(chg_en), .hyst_cancel(hyst_cancel)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    expect_bit("R11 chg_en", chg_en, 1'b1);
    expect_bit("R11 hyst_cancel", hyst_cancel, 1'b0);
  endtask

  task automatic t_oc_normal;
    oc_cell = 2'b01;
    step(1999); expect_bit("R1 before delay", chg_en, 1'b1);
    step(1);    expect_bit("R1 after delay", chg_en, 1'b0);
    oc_cell = 2'b00;
    load_present = 1'b1; #1;
    expect_bit("R3 cancel with load", hyst_cancel, 1'b1);
    load_present = 1'b0; #1;
    expect_bit("R3 no load", hyst_cancel, 1'b0);
    step(1);
    below_rel = 2'b11;
    step(79); expect_bit("R2 before release", chg_en, 1'b0);
    step(1);  expect_bit("R2 released", chg_en, 1'b1);
    load_present = 1'b1; #1;
    expect_bit("R3 no cancel when released", hyst_cancel, 1'b0);
    load_present = 1'b0;
    below_rel = 2'b00;
    step(1);
  endtask

  task automatic t_dropout_test;
    test_mode = 1'b1;
    oc_cell = 2'b10;
    step(100);
    oc_cell = 2'b00; step(1);
    oc_cell = 2'b10;
    step(124); expect_bit("R4 restart", chg_en, 1'b1);
    step(1);   expect_bit("R9 test detect 125", chg_en, 1'b0);
    oc_cell = 2'b00;
    below_rel = 2'b11;
    step(4); expect_bit("R9 test release pending", chg_en, 1'b0);
    step(1); expect_bit("R9 test release 5", chg_en, 1'b1);
    below_rel = 2'b00;
    test_mode = 1'b0;
    step(1);
  endtask

  task automatic t_xc;
    dsg_en = 1'b1;
    hv_charger = 1'b1; step(2);
    expect_bit("R5 pending", chg_en, 1'b1);
    hv_charger = 1'b0; step(1);
    hv_charger = 1'b1; step(2);
    expect_bit("R5 abandoned count restarted", chg_en, 1'b1);
    step(1); expect_bit("R5 detect", chg_en, 1'b0);
    hv_charger = 1'b0;
    step(2); expect_bit("R6 pending", chg_en, 1'b0);
    step(1); expect_bit("R6 release", chg_en, 1'b1);
  endtask

  task automatic t_xc_inhibit;
    dsg_en = 1'b0;
    hv_charger = 1'b1;
    step(10); expect_bit("R7 inhibited", chg_en, 1'b1);
    dsg_en = 1'b1;
    step(2); expect_bit("R7 count from zero", chg_en, 1'b1);
    step(1); expect_bit("R7 detect after dsg high", chg_en, 1'b0);
    hv_charger = 1'b0;
    step(3); expect_bit("R6 release again", chg_en, 1'b1);
  endtask

  task automatic t_oc_then_xc;
    test_mode = 1'b1;
    oc_cell = 2'b01;
    step(125); expect_bit("R1 test detect", chg_en, 1'b0);
    oc_cell = 2'b00;
    hv_charger = 1'b1; dsg_en = 1'b1;
    below_rel = 2'b11;
    step(5);  expect_bit("R8 no gap at release", chg_en, 1'b0);
    step(10); expect_bit("R8 still held", chg_en, 1'b0);
    zero_cell_chg = 1'b1; #1;
    expect_bit("R10 forced high", chg_en, 1'b1);
    zero_cell_chg = 1'b0; #1;
    expect_bit("R10 force removed", chg_en, 1'b0);
    below_rel = 2'b00;
    hv_charger = 1'b0;
    step(1); expect_bit("R9 test xc release 1", chg_en, 1'b1);
    test_mode = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_oc_normal();
    t_dropout_test();
    t_xc();
    t_xc_inhibit();
    t_oc_then_xc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule